// File: doc/BRIEF.md
# PLL Output Rate Calculator

This block works out the output frequency of a phase-locked loop from the frequency of its parent clock and the divider settings held in its control fields. A strobe on `start_i` captures every operand. A shared bit-serial 64-bit divider then runs a fixed chain of truncating divisions. The 32-bit result appears on `rate_o` with a one-cycle pulse on `valid_o`. Clock-tree software or a frequency monitor uses it to report the rate a PLL is running at without needing a divider of its own.

The block handles two register variants. The direct variant uses the field values as stored and can add a 24-bit fixed-point fractional term. The offset variant treats each stored field as one less than the real value. A bypass input makes the block report the parent rate unchanged. A zero divisor is never divided by: the block reports a zero rate and raises an error flag. The block does no other range checking on the dividers.

Top module: `pll_rate_calc`

## Requirements
- R1: Direct variant (`offset_i`=0) with `int_mode_i`=1: rate = floor(floor(floor(P*fb/ref)/pd1)/pd2), where P is `parent_i` and fb, ref, pd1, pd2 are the raw field values.
- R2: Direct variant with `int_mode_i`=0: floor(floor(P*frac/ref) / 2^24) is added to floor(P*fb/ref) before the two post divisions. The two terms are truncated separately.
- R3: Offset variant (`offset_i`=1): rate = floor(floor(P*(fb+1)/(ref+1))/(pd1+1)). `pd2_i`, `frac_i` and `int_mode_i` have no effect.
- R4: With `bypass_i`=1 at start, `valid_o` pulses exactly one cycle after the start cycle, with `rate_o`=P and `err_o`=0, whatever the divider fields hold (zero fields included).
- R5: Without bypass, if any effective divisor is zero (ref, pd1 or pd2 in the direct variant), `valid_o` pulses one cycle after start with `rate_o`=0 and `err_o`=1. A normal result clears `err_o`.
- R6: All products and quotients are formed at 64 bits. `rate_o` is the low 32 bits of the final quotient.
- R7: Operands are captured in the start cycle. A change on the inputs afterwards, or a `start_i` while a calculation runs, has no effect on the result and launches no second result.
- R8: Each accepted start gives exactly one single-cycle `valid_o` pulse. `rate_o` and `err_o` hold until the next completion. A start in the cycle `valid_o` is high is accepted.
- R9: After reset `valid_o`, `err_o` and `rate_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a calculation (accepted when idle) |
| parent_i | input | 32 | Parent clock rate |
| offset_i | input | 1 | 1: stored fields are value minus one |
| bypass_i | input | 1 | 1: result is the parent rate |
| int_mode_i | input | 1 | Direct variant: 1 disables the fractional term |
| fb_i | input | 13 | Feedback multiplier field |
| ref_i | input | 6 | Reference divider field |
| pd1_i | input | 4 | First post divider field |
| pd2_i | input | 3 | Second post divider field (direct variant) |
| frac_i | input | 24 | Fraction, units of 2^-24 (direct variant) |
| rate_o | output | 32 | Computed output rate |
| valid_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | Last result hit a zero divisor |

## Verification
Two functions can land in the same cycle: a result completes and a new start is accepted. The bench provokes this by raising `start_i` in the very cycle `valid_o` is seen high. The new start carries bypass together with all-zero divider fields, so a second contention, bypass against the zero-divisor guard, is settled in the same step. The bench judges that the first result is correct in its pulse cycle. It then requires the second pulse in the next cycle, carrying the parent rate with no error.

// File: rtl/pll_rate_pkg.sv
package pll_rate_pkg;
  localparam int ACC_W = 64;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INT,
    ST_FRAC,
    ST_POST1,
    ST_POST2
  } calc_state_e;
endpackage

// File: rtl/pll_rate_div.sv
module pll_rate_div #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         go_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         done_o,
  output logic [W-1:0] quo_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  quo_q, den_q, num_q;
  logic [W:0]    rem_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;

  logic [W:0]    rem_sh, rem_nx;
  logic          fits;

  // restoring step: one quotient bit per cycle
  always_comb begin
    rem_sh = {rem_q[W-1:0], quo_q[W-1]};
    fits   = rem_sh >= {1'b0, den_q};
    rem_nx = fits ? rem_sh - {1'b0, den_q} : rem_sh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q  <= '0;
      den_q  <= '0;
      num_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        rem_q <= rem_nx;
        quo_q <= {quo_q[W-2:0], fits};
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (go_i) begin
        quo_q  <= num_i;
        num_q  <= num_i;
        den_q  <= den_i;
        rem_q  <= '0;
        cnt_q  <= CW'(W);
        busy_q <= 1'b1;
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;

  AST_DIV_REM_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (rem_q < {1'b0, den_q})); // R6
  AST_DIV_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> ((quo_q * den_q + rem_q[W-1:0]) == num_q)); // R6
endmodule

// File: rtl/pll_rate_ctrl.sv
module pll_rate_ctrl
  import pll_rate_pkg::*;
#(
  parameter int RATE_W = 32,
  parameter int FB_W   = 13,
  parameter int REF_W  = 6,
  parameter int PD1_W  = 4,
  parameter int PD2_W  = 3,
  parameter int FRAC_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [RATE_W-1:0] parent_i,
  input  logic              offset_i,
  input  logic              bypass_i,
  input  logic              int_mode_i,
  input  logic [FB_W-1:0]   fb_i,
  input  logic [REF_W-1:0]  ref_i,
  input  logic [PD1_W-1:0]  pd1_i,
  input  logic [PD2_W-1:0]  pd2_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              div_go_o,
  output logic [ACC_W-1:0]  div_num_o,
  output logic [ACC_W-1:0]  div_den_o,
  input  logic              div_done_i,
  input  logic [ACC_W-1:0]  div_quo_i,
  output logic [RATE_W-1:0] rate_o,
  output logic              valid_o,
  output logic              err_o
);
  localparam int NF_W = FB_W + 1;
  localparam int NR_W = REF_W + 1;
  localparam int NO_W = PD1_W + 1;

  calc_state_e       state_q;
  logic [RATE_W-1:0] par_q;
  logic [NR_W-1:0]   nr_q;
  logic [NO_W-1:0]   no_q;
  logic [PD2_W-1:0]  p2_q;
  logic [FRAC_W-1:0] frac_q;
  logic              frac_on_q;
  logic [ACC_W-1:0]  acc_q;
  logic [RATE_W-1:0] rate_q;
  logic              valid_q, err_q;

  logic [NF_W-1:0]   eff_nf;
  logic [NR_W-1:0]   eff_nr;
  logic [NO_W-1:0]   eff_no;
  logic [PD2_W-1:0]  eff_p2;
  logic              eff_frac, zero_div;

  // effective field values per register variant
  always_comb begin
    if (offset_i) begin
      eff_nf   = NF_W'(fb_i) + NF_W'(1);
      eff_nr   = NR_W'(ref_i) + NR_W'(1);
      eff_no   = NO_W'(pd1_i) + NO_W'(1);
      eff_p2   = PD2_W'(1);
      eff_frac = 1'b0;
    end else begin
      eff_nf   = NF_W'(fb_i);
      eff_nr   = NR_W'(ref_i);
      eff_no   = NO_W'(pd1_i);
      eff_p2   = pd2_i;
      eff_frac = !int_mode_i;
    end
    zero_div = (eff_nr == '0) || (eff_no == '0) || (eff_p2 == '0);
  end

  always_comb begin
    div_go_o  = 1'b0;
    div_num_o = '0;
    div_den_o = '0;
    unique case (state_q)
      ST_IDLE: if (start_i && !bypass_i && !zero_div) begin
        div_go_o  = 1'b1;
        div_num_o = ACC_W'(parent_i) * ACC_W'(eff_nf);
        div_den_o = ACC_W'(eff_nr);
      end
      ST_INT: if (div_done_i) begin
        div_go_o = 1'b1;
        if (frac_on_q) begin
          div_num_o = ACC_W'(par_q) * ACC_W'(frac_q);
          div_den_o = ACC_W'(nr_q);
        end else begin
          div_num_o = div_quo_i;
          div_den_o = ACC_W'(no_q);
        end
      end
      ST_FRAC: if (div_done_i) begin
        div_go_o  = 1'b1;
        div_num_o = acc_q + (div_quo_i >> FRAC_W);
        div_den_o = ACC_W'(no_q);
      end
      ST_POST1: if (div_done_i) begin
        div_go_o  = 1'b1;
        div_num_o = div_quo_i;
        div_den_o = ACC_W'(p2_q);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      par_q     <= '0;
      nr_q      <= '0;
      no_q      <= '0;
      p2_q      <= '0;
      frac_q    <= '0;
      frac_on_q <= 1'b0;
      acc_q     <= '0;
      rate_q    <= '0;
      valid_q   <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          par_q     <= parent_i;
          nr_q      <= eff_nr;
          no_q      <= eff_no;
          p2_q      <= eff_p2;
          frac_q    <= frac_i;
          frac_on_q <= eff_frac;
          if (bypass_i) begin
            rate_q  <= parent_i;
            err_q   <= 1'b0;
            valid_q <= 1'b1;
          end else if (zero_div) begin
            rate_q  <= '0;
            err_q   <= 1'b1;
            valid_q <= 1'b1;
          end else begin
            state_q <= ST_INT;
          end
        end
        ST_INT: if (div_done_i) begin
          acc_q   <= div_quo_i;
          state_q <= frac_on_q ? ST_FRAC : ST_POST1;
        end
        ST_FRAC:  if (div_done_i) state_q <= ST_POST1;
        ST_POST1: if (div_done_i) state_q <= ST_POST2;
        ST_POST2: if (div_done_i) begin
          rate_q  <= div_quo_i[RATE_W-1:0];
          err_q   <= 1'b0;
          valid_q <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rate_o  = rate_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;

  AST_NO_ZERO_DIVISOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_go_o |-> (div_den_o != '0)); // R5
  AST_ERR_ZERO_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && err_o) |-> (rate_o == '0)); // R5
  AST_BYPASS_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i && bypass_i) |=>
      (valid_o && !err_o && rate_o == $past(parent_i))); // R4
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(rate_o) && $stable(err_o))); // R8
  AST_BUSY_NO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && state_q != ST_POST2) |=> !valid_o); // R7
endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc
  import pll_rate_pkg::*;
#(
  parameter int RATE_W = 32,
  parameter int FB_W   = 13,
  parameter int REF_W  = 6,
  parameter int PD1_W  = 4,
  parameter int PD2_W  = 3,
  parameter int FRAC_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [RATE_W-1:0] parent_i,
  input  logic              offset_i,
  input  logic              bypass_i,
  input  logic              int_mode_i,
  input  logic [FB_W-1:0]   fb_i,
  input  logic [REF_W-1:0]  ref_i,
  input  logic [PD1_W-1:0]  pd1_i,
  input  logic [PD2_W-1:0]  pd2_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic [RATE_W-1:0] rate_o,
  output logic              valid_o,
  output logic              err_o
);
  logic             div_go, div_done;
  logic [ACC_W-1:0] div_num, div_den, div_quo;

  pll_rate_ctrl #(
    .RATE_W(RATE_W), .FB_W(FB_W), .REF_W(REF_W),
    .PD1_W(PD1_W), .PD2_W(PD2_W), .FRAC_W(FRAC_W)
  ) ctrl_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .parent_i   (parent_i),
    .offset_i   (offset_i),
    .bypass_i   (bypass_i),
    .int_mode_i (int_mode_i),
    .fb_i       (fb_i),
    .ref_i      (ref_i),
    .pd1_i      (pd1_i),
    .pd2_i      (pd2_i),
    .frac_i     (frac_i),
    .div_go_o   (div_go),
    .div_num_o  (div_num),
    .div_den_o  (div_den),
    .div_done_i (div_done),
    .div_quo_i  (div_quo),
    .rate_o     (rate_o),
    .valid_o    (valid_o),
    .err_o      (err_o)
  );

  pll_rate_div #(.W(ACC_W)) div_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (div_go),
    .num_i  (div_num),
    .den_i  (div_den),
    .done_o (div_done),
    .quo_o  (div_quo)
  );
endmodule

// File: tb/pll_rate_calc_tb_top.sv
module pll_rate_calc_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] parent_i = '0;
  logic        offset_i = 1'b0;
  logic        bypass_i = 1'b0;
  logic        int_mode_i = 1'b1;
  logic [12:0] fb_i = '0;
  logic [5:0]  ref_i = '0;
  logic [3:0]  pd1_i = '0;
  logic [2:0]  pd2_i = '0;
  logic [23:0] frac_i = '0;
  logic [31:0] rate_o;
  logic        valid_o, err_o;

  int n_chk = 0;
  int n_err = 0;
  int cycles = 0;
  bit done_flag = 1'b0;

  always #5 clk_i = ~clk_i;

  pll_rate_calc dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .parent_i(parent_i),
    .offset_i(offset_i), .bypass_i(bypass_i), .int_mode_i(int_mode_i),
    .fb_i(fb_i), .ref_i(ref_i), .pd1_i(pd1_i), .pd2_i(pd2_i), .frac_i(frac_i),
    .rate_o(rate_o), .valid_o(valid_o), .err_o(err_o)
  );

  typedef struct {
    logic        off, byp, intm;
    logic [31:0] p;
    logic [12:0] fb;
    logic [5:0]  rf;
    logic [3:0]  p1;
    logic [2:0]  p2;
    logic [23:0] fr;
  } op_t;

  // expected {err, rate} from the requirements
  function automatic logic [32:0] model(op_t o);
    logic [63:0] nf, nr, no, n2, s;
    if (o.byp) return {1'b0, o.p};
    if (o.off) begin
      nf = 64'(o.fb) + 1; nr = 64'(o.rf) + 1; no = 64'(o.p1) + 1; n2 = 1;
    end else begin
      nf = 64'(o.fb); nr = 64'(o.rf); no = 64'(o.p1); n2 = 64'(o.p2);
    end
    if (nr == 0 || no == 0 || n2 == 0) return {1'b1, 32'd0};
    s = (64'(o.p) * nf) / nr;
    if (!o.off && !o.intm) s = s + (((64'(o.p) * 64'(o.fr)) / nr) >> 24);
    s = (s / no) / n2;
    return {1'b0, s[31:0]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(op_t o);
    offset_i = o.off; bypass_i = o.byp; int_mode_i = o.intm; parent_i = o.p;
    fb_i = o.fb; ref_i = o.rf; pd1_i = o.p1; pd2_i = o.p2; frac_i = o.fr;
  endtask

  task automatic wait_valid(output int lat);
    lat = 1;
    while (!valid_o && lat < 2000) begin
      @(negedge clk_i);
      lat++;
    end
  endtask

  task automatic run_op(op_t o, input string req);
    logic [32:0] exp;
    int lat;
    exp = model(o);
    drive(o);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_valid(lat);
    check(valid_o, req, 64'(valid_o), 64'd1);
    check(rate_o == exp[31:0], req, 64'(rate_o), 64'(exp[31:0]));
    check(err_o == exp[32], req, 64'(err_o), 64'(exp[32]));
    if (o.byp || exp[32]) check(lat == 1, req, 64'(lat), 64'd1);
    @(negedge clk_i);
    check(!valid_o, "R8", 64'(valid_o), 64'd0);
  endtask

  function automatic op_t mk(logic off, logic byp, logic intm, logic [31:0] p, logic [12:0] fb,
                             logic [5:0] rf, logic [3:0] p1, logic [2:0] p2, logic [23:0] fr);
    op_t o;
    o.off = off; o.byp = byp; o.intm = intm; o.p = p; o.fb = fb;
    o.rf = rf; o.p1 = p1; o.p2 = p2; o.fr = fr;
    return o;
  endfunction

  int          ref_set[5] = '{0, 1, 3, 7, 63};
  int          pd1_set[4] = '{0, 1, 2, 15};
  int          pd2_set[4] = '{0, 1, 3, 7};
  logic [31:0] par_set[3] = '{32'd24000000, 32'd32768, 32'hFFFFFFFF};
  logic [12:0] fb_set[3]  = '{13'd99, 13'd1, 13'd8191};
  logic [23:0] fr_set[3]  = '{24'h800000, 24'h000001, 24'hFFFFFF};

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 190000 && !done_flag) begin
      done_flag = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected below 190000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    op_t a, b;
    logic [32:0] ea;
    int lat, pulses;
    logic [31:0] held;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R9: reset state
    check(!valid_o, "R9", 64'(valid_o), 64'd0);
    check(rate_o == 0, "R9", 64'(rate_o), 64'd0);
    check(!err_o, "R9", 64'(err_o), 64'd0);

    // R1 / R5: integer direct variant sweep, zero divisors included
    for (int k = 0; k < 3; k++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 4; j++)
          for (int m = 0; m < 4; m++)
            run_op(mk(1'b0, 1'b0, 1'b1, par_set[k], fb_set[k], 6'(ref_set[i]),
                      4'(pd1_set[j]), 3'(pd2_set[m]), 24'h123456), "R1_R5");

    // R2: fractional term, separately truncated
    for (int k = 0; k < 3; k++)
      for (int i = 1; i < 5; i++)
        for (int j = 1; j < 4; j++)
          run_op(mk(1'b0, 1'b0, 1'b0, par_set[k], fb_set[k], 6'(ref_set[i]),
                    4'(pd1_set[j]), 3'(pd2_set[j]), fr_set[k]), "R2");

    // R3: offset variant, pd2/frac/int_mode must not matter
    for (int k = 0; k < 3; k++)
      for (int i = 0; i < 3; i++)
        for (int j = 0; j < 3; j++)
          run_op(mk(1'b1, 1'b0, 1'(j), par_set[k], fb_set[k], 6'(ref_set[i * 2]),
                    4'(pd1_set[j + 1]), 3'(j), 24'hABCDEF), "R3");

    // R4: bypass, with and without zero fields
    run_op(mk(1'b0, 1'b1, 1'b1, 32'd12345678, 13'd5, 6'd0, 4'd0, 3'd0, 24'd0), "R4");
    run_op(mk(1'b1, 1'b1, 1'b0, 32'hDEADBEEF, 13'd77, 6'd2, 4'd3, 3'd1, 24'd9), "R4");

    // R6: 64-bit intermediate, low 32 bits out
    run_op(mk(1'b0, 1'b0, 1'b1, 32'hFFFFFFFF, 13'd8191, 6'd1, 4'd1, 3'd1, 24'd0), "R6");
    check(rate_o == 32'hFFFFE001, "R6", 64'(rate_o), 64'hFFFFE001);

    // R7: late input changes and a mid-run start are ignored
    a = mk(1'b0, 1'b0, 1'b0, 32'd50000000, 13'd600, 6'd3, 4'd2, 3'd3, 24'h400000);
    b = mk(1'b0, 1'b1, 1'b1, 32'd7, 13'd1, 6'd1, 4'd1, 3'd1, 24'd0);
    ea = model(a);
    drive(a);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (5) @(negedge clk_i);
    drive(b);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_valid(lat);
    check(rate_o == ea[31:0], "R7", 64'(rate_o), 64'(ea[31:0]));
    check(err_o == ea[32], "R7", 64'(err_o), 64'(ea[32]));
    pulses = 0;
    held = rate_o;
    for (int t = 0; t < 300; t++) begin
      @(negedge clk_i);
      if (valid_o) pulses++;
    end
    check(pulses == 0, "R7", 64'(pulses), 64'd0);
    // R8: result holds without a start
    check(rate_o == held, "R8", 64'(rate_o), 64'(held));

    // R8: start in the pulse cycle; bypass beats zero-divisor guard
    a = mk(1'b0, 1'b0, 1'b1, 32'd1000000, 13'd10, 6'd1, 4'd2, 3'd5, 24'd0);
    b = mk(1'b0, 1'b1, 1'b1, 32'd4242, 13'd0, 6'd0, 4'd0, 3'd0, 24'd0);
    ea = model(a);
    drive(a);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_valid(lat);
    check(valid_o && rate_o == ea[31:0], "R8", 64'(rate_o), 64'(ea[31:0]));
    drive(b);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check(valid_o, "R8", 64'(valid_o), 64'd1);
    check(rate_o == 32'd4242, "R4", 64'(rate_o), 64'd4242);
    check(!err_o, "R4", 64'(err_o), 64'd0);
    @(negedge clk_i);
    check(!valid_o, "R8", 64'(valid_o), 64'd0);

    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule